// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static memory with a data path split into byte lanes (four lanes of eight bits by default) and a small parameterised depth. Every control, address and write-data input is captured on the rising clock edge. Read data passes through an output register and appears one cycle after its address is taken. Instead of a bidirectional pin, the block has separate write-data and read-data ports and a drive-enable output, which says when the read-data port would be driving the shared bus.

An access starts when one of two address strobes is active and the chip-select inputs select the device. The processor strobe always opens a read. The controller strobe performs a write at once when the write controls ask for one. After a start, the block keeps the accessed row. Each later cycle with no strobe continues at the current word or, when the advance input is low, at the next word of a four-word wrapping burst, and the write controls pick read or write. A global write overrides the per-lane selects. A sleep input, taken through a short synchroniser, blocks access and silences the output while the contents are kept.

Top module: `burst_sram`

## Requirements
- R1: An access starts at a clock edge only when a strobe is seen and all three selects are active (`sel1_n` low, `sel2` high, `sel3_n` low). A strobe with any select inactive writes nothing. Without a strobe, an idle (deselected) device performs no access even when the write controls are active.
- R2: When both strobes are low with `sel1_n` low, the processor strobe wins, and the cycle is a read even if the write controls are active. While `sel1_n` is high, the processor strobe is ignored completely, so a running burst continues as if no strobe were present.
- R3: A start by the processor strobe is a read whose data is returned, whatever `gwr_n`, `bwr_n`, `lane_sel_n` and `adv_n` are. A write to that address is possible on a following cycle without a strobe.
- R4: A start by the controller strobe with the write condition true writes `wdata` to `addr` in that cycle, and `adv_n` is ignored in that cycle.
- R5: The write condition is true when `gwr_n` is low, or when `bwr_n` is low and at least one bit of `lane_sel_n` is low. Bit i of `lane_sel_n` selects lane i, which is `wdata[8i+7:8i]`. With `gwr_n` low, all lanes are written. With `bwr_n` low and every select high, the cycle is a read.
- R6: During a lane write, lanes that are not selected keep their old contents.
- R7: For a read accepted at edge k, `rdata` carries the word after edge k+1. Until that edge, it keeps the word of the previous read.
- R8: In a cycle without a strobe after a start, `adv_n` low moves the two low address bits to the next word of the burst and `adv_n` high keeps the current word. The upper address bits stay fixed, and the low bits wrap within four words. The default order is linear (start+1, +2, +3 modulo 4). A parameter selects the interleaved order (start XOR step).
- R9: `rdata_oe` is low whenever `oe_n` is high and during the cycle after a write is accepted, whatever `oe_n` is. A change of `oe_n` reaches `rdata_oe` without waiting for a clock.
- R10: A strobe seen with the device deselected turns `rdata_oe` off right after that edge. After a new start, `rdata_oe` stays off during the first cycle and comes on when the data arrives.
- R11: The `sleep` input takes effect through two flops. With `sleep` high before edges k and k+1, `rdata_oe` is off after edge k+1, and accesses from edge k+2 onward are dropped. After `sleep` falls before edge j, an access at edge j+1 is still dropped and one at edge j+2 is served. Stored data is kept.
- R12: A synchronous active-high `rst` clears the pipeline and turns `rdata_oe` off. It does not change the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel1_n | input | 1 | Chip select one, active low; also qualifies the processor strobe |
| sel2 | input | 1 | Chip select two, active high |
| sel3_n | input | 1 | Chip select three, active low |
| astb_p_n | input | 1 | Processor address strobe, active low |
| astb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | High while read data would be driven onto the bus |

## Verification
The hardest case to reach from the ports is the write that follows a processor-strobe start. It needs a read start with the write controls already active, then a cycle with no strobe that carries the real write. Between the two, the returned word must be the old one, and the output must be forced off during the write cycle even though `oe_n` is low. The stimulus builds this as a three-edge sequence at one address and then reads back through a fresh controller start. The sleep boundaries and the wrapping burst are timed edge by edge in the same way.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   // Kind of array access carried by the input stage.
   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2
   } bsr_acc_e;

endpackage

// File: rtl/bsr_cmd_decode.sv
module bsr_cmd_decode
   import burst_sram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lock,
   input  logic             proc_n,
   input  logic             ctrl_n,
   input  logic             sel1_n,
   input  logic             sel2,
   input  logic             sel3_n,
   input  logic             adv_n,
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [LANES-1:0] lane_sel_n,
   output bsr_acc_e         kind,
   output logic             load,
   output logic             adv_go,
   output logic             kill,
   output logic [LANES-1:0] lanes_we
);

   logic active_q;
   logic proc_seen;
   logic start;
   logic chip_on;
   logic wr_req;

   always_comb begin
      proc_seen = !proc_n && !sel1_n;
      start     = proc_seen || !ctrl_n;
      chip_on   = !sel1_n && sel2 && !sel3_n;
      wr_req    = !gwr_n || (!bwr_n && (lane_sel_n != {LANES{1'b1}}));
      kind      = ACC_IDLE;
      load      = 1'b0;
      adv_go    = 1'b0;
      kill      = 1'b0;
      if (lock) begin
         kill = 1'b1;
      end else if (start && chip_on) begin
         load = 1'b1;
         kind = (proc_seen || !wr_req) ? ACC_RD : ACC_WR;
      end else if (start) begin
         kill = 1'b1;
      end else if (active_q) begin
         adv_go = !adv_n;
         kind   = wr_req ? ACC_WR : ACC_RD;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane_we
      assign lanes_we[g] = !gwr_n || (!bwr_n && !lane_sel_n[g]);
   end

   always_ff @(posedge clk) begin
      if (rst)       active_q <= 1'b0;
      else if (load) active_q <= 1'b1;
      else if (kill) active_q <= 1'b0;
   end

endmodule

// File: rtl/bsr_burst_addr.sv
module bsr_burst_addr #(
   parameter int ADDR_W     = 6,
   parameter bit INTERLEAVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              adv_go,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] acc_addr
);

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        step_q;
   logic [1:0]        step_eff;
   logic [1:0]        lo;

   assign step_eff = step_q + {1'b0, adv_go};

   if (INTERLEAVE) begin : g_xor_order
      assign lo = base_q[1:0] ^ step_eff;
   end else begin : g_lin_order
      assign lo = base_q[1:0] + step_eff;
   end

   assign acc_addr = load ? addr_in : {base_q[ADDR_W-1:2], lo};

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         step_q <= '0;
      end else if (load) begin
         base_q <= addr_in;
         step_q <= '0;
      end else if (adv_go) begin
         step_q <= step_eff;
      end
   end

endmodule

// File: rtl/bsr_lane_array.sv
module bsr_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_lanes,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_q
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] q_r;

      always_ff @(posedge clk) begin
         if (wr_en && wr_lanes[g]) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
         if (rd_en)                q_r <= cells[rd_addr];
      end

      assign rd_q[g*LANE_W +: LANE_W] = q_r;
   end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LANES      = 4,
   parameter int LANE_W     = 8,
   parameter bit INTERLEAVE = 1'b0,
   parameter int SLEEP_SYNC = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    sel3_n,
   input  logic                    astb_p_n,
   input  logic                    astb_c_n,
   input  logic                    adv_n,
   input  logic                    gwr_n,
   input  logic                    bwr_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    oe_n,
   input  logic                    sleep,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("burst_sram: ADDR_W must cover a four-word burst");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram: lane count and width must be positive");
   end
   if (SLEEP_SYNC < 2) begin : g_bad_sync
      $error("burst_sram: SLEEP_SYNC must be at least 2");
   end

   // Sleep request synchroniser; its last stage is the sleep state.
   logic [SLEEP_SYNC-1:0] zz_pipe;
   logic                  sleep_st;

   always_ff @(posedge clk) begin
      if (rst) zz_pipe <= '0;
      else     zz_pipe <= {zz_pipe[SLEEP_SYNC-2:0], sleep};
   end
   assign sleep_st = zz_pipe[SLEEP_SYNC-1];

   bsr_acc_e          kind;
   logic              load;
   logic              adv_go;
   logic              kill;
   logic [LANES-1:0]  lanes_we;
   logic [ADDR_W-1:0] acc_addr;

   bsr_cmd_decode #(.LANES(LANES)) u_decode (
      .clk        (clk),
      .rst        (rst),
      .lock       (sleep_st),
      .proc_n     (astb_p_n),
      .ctrl_n     (astb_c_n),
      .sel1_n     (sel1_n),
      .sel2       (sel2),
      .sel3_n     (sel3_n),
      .adv_n      (adv_n),
      .gwr_n      (gwr_n),
      .bwr_n      (bwr_n),
      .lane_sel_n (lane_sel_n),
      .kind       (kind),
      .load       (load),
      .adv_go     (adv_go),
      .kill       (kill),
      .lanes_we   (lanes_we)
   );

   bsr_burst_addr #(.ADDR_W(ADDR_W), .INTERLEAVE(INTERLEAVE)) u_burst (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .adv_go   (adv_go),
      .addr_in  (addr),
      .acc_addr (acc_addr)
   );

   // Input stage: the access taken at this edge.
   bsr_acc_e          s1_kind;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_lanes;
   logic [DATA_W-1:0] s1_data;
   logic              out_vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_kind   <= ACC_IDLE;
         out_vld_q <= 1'b0;
      end else begin
         s1_kind   <= kind;
         out_vld_q <= !kill && (s1_kind == ACC_RD);
      end
      s1_addr  <= acc_addr;
      s1_lanes <= lanes_we;
      s1_data  <= wdata;
   end

   bsr_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk      (clk),
      .wr_en    (s1_kind == ACC_WR),
      .wr_addr  (s1_addr),
      .wr_lanes (s1_lanes),
      .wr_data  (s1_data),
      .rd_en    (s1_kind == ACC_RD),
      .rd_addr  (s1_addr),
      .rd_q     (rdata)
   );

   assign rdata_oe = out_vld_q && !oe_n && (s1_kind != ACC_WR) && !sleep_st;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             sel1_n,
   input logic             sel2,
   input logic             sel3_n,
   input logic             astb_p_n,
   input logic             astb_c_n,
   input logic             gwr_n,
   input logic             bwr_n,
   input logic [LANES-1:0] lane_sel_n,
   input logic             sleep,
   input logic             rdata_oe
);

   logic strobe_seen;
   logic chip_on;
   logic wr_req;

   assign strobe_seen = !astb_c_n || (!astb_p_n && !sel1_n);
   assign chip_on     = !sel1_n && sel2 && !sel3_n;
   assign wr_req      = !gwr_n || (!bwr_n && (lane_sel_n != {LANES{1'b1}}));

   // R12: reset leaves the output off.
   a_r12_reset_quiet: assert property (@(posedge clk) rst |=> !rdata_oe);

   // R10: a strobe while deselected silences the output at once.
   a_r10_deselect_off: assert property (@(posedge clk) disable iff (rst)
      (strobe_seen && !chip_on) |=> !rdata_oe);

   // R9: a controller-strobe write keeps the output off in the next cycle.
   a_r9_write_quiet: assert property (@(posedge clk) disable iff (rst)
      (!astb_c_n && astb_p_n && chip_on && wr_req) |=> !rdata_oe);

   // R11: two sampled sleep edges mean the output is off.
   a_r11_sleep_off: assert property (@(posedge clk) disable iff (rst)
      (sleep && $past(sleep)) |=> !rdata_oe);

endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .sel1_n     (sel1_n),
   .sel2       (sel2),
   .sel3_n     (sel3_n),
   .astb_p_n   (astb_p_n),
   .astb_c_n   (astb_c_n),
   .gwr_n      (gwr_n),
   .bwr_n      (bwr_n),
   .lane_sel_n (lane_sel_n),
   .sleep      (sleep),
   .rdata_oe   (rdata_oe)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sel1_n, sel2, sel3_n, astb_p_n, astb_c_n, adv_n, gwr_n, bwr_n;
   logic [3:0]  lane_sel_n;
   logic [5:0]  addr;
   logic [31:0] wdata;
   logic        oe_n = 1'b0;
   logic        sleep = 1'b0;
   logic [31:0] rdata;
   logic        rdata_oe;

   int nchk = 0;
   int nerr = 0;
   logic [31:0] ref_mem [64];

   always #5 clk = ~clk;

   burst_sram u_burst_sram (
      .clk(clk), .rst(rst), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .astb_p_n(astb_p_n), .astb_c_n(astb_c_n), .adv_n(adv_n), .gwr_n(gwr_n),
      .bwr_n(bwr_n), .lane_sel_n(lane_sel_n), .addr(addr), .wdata(wdata),
      .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      astb_p_n = 1'b1; astb_c_n = 1'b1; adv_n = 1'b1;
      gwr_n = 1'b1; bwr_n = 1'b1; lane_sel_n = 4'hF;
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
   endtask

   task automatic ref_write(input int a, input logic [31:0] d, input logic [3:0] lanes);
      for (int i = 0; i < 4; i++)
         if (lanes[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
   endtask

   // Controller-strobe write: global when use_gw, else lane write.
   task automatic ctrl_wr(input int a, input logic [31:0] d, input logic [3:0] lsel_n, input bit use_gw);
      idle();
      astb_c_n = 1'b0; addr = 6'(a); wdata = d;
      if (use_gw) gwr_n = 1'b0;
      else begin bwr_n = 1'b0; lane_sel_n = lsel_n; end
      step();
      idle();
      ref_write(a, d, use_gw ? 4'hF : ~lsel_n);
   endtask

   task automatic ctrl_rd(input int a);
      idle();
      astb_c_n = 1'b0; addr = 6'(a);
      step();
      idle();
   endtask

   task automatic t_reset_state();
      idle(); addr = '0; wdata = '0;
      repeat (3) step();
      rst = 1'b0;
      chk("R12 output off after reset", {31'd0, rdata_oe}, 32'd0);
      for (int i = 0; i < 64; i++)
         ctrl_wr(i, 32'h5A3C_0000 + i * 32'h0001_0203, 4'hF, 1'b1);
   endtask

   task automatic t_ctrl_write();
      logic [31:0] d = 32'hDEAD_BEEF;
      idle(); astb_c_n = 1'b0; addr = 6'd5; gwr_n = 1'b0; adv_n = 1'b0; wdata = d;
      step(); idle(); ref_write(5, d, 4'hF);
      step();
      step();
      chk("R4 write taken in start cycle, advance ignored", rdata, d);
      chk("R4 output on for following read", {31'd0, rdata_oe}, 32'd1);
      ctrl_rd(12);
      chk("R7 previous word held until next edge", rdata, ref_mem[5]);
      step();
      chk("R7 word arrives one edge later", rdata, ref_mem[12]);
   endtask

   task automatic t_lanes();
      logic [31:0] old22 = ref_mem[22];
      ctrl_wr(20, 32'h1122_3344, 4'b1010, 1'b0);
      ctrl_rd(20); step();
      chk("R6 unselected lanes kept", rdata, ref_mem[20]);
      idle(); astb_c_n = 1'b0; addr = 6'd21; gwr_n = 1'b0; bwr_n = 1'b1; wdata = 32'hCAFE_F00D;
      step(); idle(); ref_write(21, 32'hCAFE_F00D, 4'hF);
      ctrl_rd(21); step();
      chk("R5 global write covers all lanes", rdata, 32'hCAFE_F00D);
      idle(); astb_c_n = 1'b0; addr = 6'd22; bwr_n = 1'b0; lane_sel_n = 4'hF; wdata = 32'h0;
      step(); idle(); step();
      chk("R5 no lane selected means read", rdata, old22);
      chk("R5 no lane selected output on", {31'd0, rdata_oe}, 32'd1);
   endtask

   task automatic t_proc_start();
      logic [31:0] old9 = ref_mem[9];
      idle(); astb_p_n = 1'b0; addr = 6'd9; gwr_n = 1'b0; wdata = 32'h0BAD_0BAD;
      step(); idle(); step();
      chk("R3 processor start returns old word", rdata, old9);
      chk("R3 processor start output on", {31'd0, rdata_oe}, 32'd1);
      idle(); gwr_n = 1'b0; wdata = 32'h7777_1234;
      step(); idle(); ref_write(9, 32'h7777_1234, 4'hF);
      chk("R9 output off in write cycle with oe low", {31'd0, rdata_oe}, 32'd0);
      ctrl_rd(9); step();
      chk("R3 follow-up write landed", rdata, 32'h7777_1234);
   endtask

   task automatic t_strobe_priority();
      logic [31:0] old30 = ref_mem[30];
      idle(); astb_p_n = 1'b0; astb_c_n = 1'b0; addr = 6'd30; gwr_n = 1'b0; wdata = 32'h1;
      step(); idle(); step();
      chk("R2 both strobes read old word", rdata, old30);
      chk("R2 both strobes output on", {31'd0, rdata_oe}, 32'd1);
      ctrl_rd(16);
      astb_p_n = 1'b0; sel1_n = 1'b1; adv_n = 1'b0;
      step(); idle(); step();
      chk("R2 processor strobe ignored with sel1 high", rdata, ref_mem[17]);
      chk("R2 burst kept running", {31'd0, rdata_oe}, 32'd1);
   endtask

   task automatic t_selects();
      logic [31:0] o40 = ref_mem[40];
      logic [31:0] o41 = ref_mem[41];
      logic [31:0] o42 = ref_mem[42];
      idle(); astb_c_n = 1'b0; sel2 = 1'b0; addr = 6'd40; gwr_n = 1'b0; wdata = 32'h4040_4040;
      step();
      chk("R10 deselect turns output off", {31'd0, rdata_oe}, 32'd0);
      idle(); astb_c_n = 1'b0; sel3_n = 1'b1; addr = 6'd41; gwr_n = 1'b0; wdata = 32'h4141_4141;
      step();
      idle(); addr = 6'd42; gwr_n = 1'b0; wdata = 32'h4242_4242;
      step(); idle();
      ctrl_rd(40); step();
      chk("R1 write with sel2 low dropped", rdata, o40);
      ctrl_rd(41); step();
      chk("R1 write with sel3 high dropped", rdata, o41);
      ctrl_rd(42); step();
      chk("R1 no strobe while idle dropped", rdata, o42);
   endtask

   task automatic t_burst();
      int          seq [5] = '{34, 35, 32, 32, 33};
      logic [3:0]  advp = 4'b0100;
      ctrl_rd(34);
      for (int i = 1; i < 5; i++) begin
         adv_n = advp[i-1];
         step();
         chk("R8 burst word order", rdata, ref_mem[seq[i-1]]);
      end
      idle(); step();
      chk("R8 burst wraps within four words", rdata, ref_mem[seq[4]]);
   endtask

   task automatic t_reselect();
      ctrl_rd(3);
      astb_c_n = 1'b0; sel2 = 1'b0;
      step();
      chk("R10 output off right after deselect", {31'd0, rdata_oe}, 32'd0);
      ctrl_rd(4);
      chk("R10 output off first cycle after reselect", {31'd0, rdata_oe}, 32'd0);
      step();
      chk("R10 data after reselect", rdata, ref_mem[4]);
      chk("R10 output on after reselect", {31'd0, rdata_oe}, 32'd1);
   endtask

   task automatic t_oe();
      ctrl_rd(6);
      oe_n = 1'b1;
      step();
      chk("R9 oe high keeps output off", {31'd0, rdata_oe}, 32'd0);
      oe_n = 1'b0;
      #1;
      chk("R9 oe low drives without clock", {31'd0, rdata_oe}, 32'd1);
      chk("R9 data under oe", rdata, ref_mem[6]);
   endtask

   task automatic t_sleep();
      logic [31:0] o7 = ref_mem[7];
      ctrl_rd(50); step();
      sleep = 1'b1;
      step();
      chk("R11 still awake one edge after request", {31'd0, rdata_oe}, 32'd1);
      step();
      chk("R11 asleep two edges after request", {31'd0, rdata_oe}, 32'd0);
      idle(); astb_c_n = 1'b0; addr = 6'd7; gwr_n = 1'b0; wdata = 32'h7E7E_7E7E;
      step(); idle(); step();
      chk("R11 output off while asleep", {31'd0, rdata_oe}, 32'd0);
      sleep = 1'b0;
      step();
      idle(); astb_c_n = 1'b0; addr = 6'd7; gwr_n = 1'b0; wdata = 32'h7F7F_7F7F;
      step(); idle();
      ctrl_rd(7); step();
      chk("R11 writes dropped in sleep and on exit edge", rdata, o7);
      chk("R11 access served after exit", {31'd0, rdata_oe}, 32'd1);
   endtask

   task automatic t_reset_keeps();
      rst = 1'b1; step();
      chk("R12 output off in reset", {31'd0, rdata_oe}, 32'd0);
      rst = 1'b0; idle(); step();
      ctrl_rd(21); step();
      chk("R12 contents kept across reset", rdata, ref_mem[21]);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired before the run ended");
      summary();
   end

   initial begin
      idle(); addr = '0; wdata = '0;
      @(negedge clk);
      t_reset_state();
      t_ctrl_write();
      t_lanes();
      t_proc_start();
      t_strobe_priority();
      t_selects();
      t_burst();
      t_reselect();
      t_oe();
      t_sleep();
      t_reset_keeps();
      summary();
   end

endmodule